// File: doc/BRIEF.md
# Pointer Bounds Register Check Unit

This block keeps a small file of pointer bounds registers and checks memory access addresses against them. Each register packs a 64-bit lower limit and a 64-bit upper limit into one 128-bit word. The lower limit is the first legal byte address and the upper limit is the last legal byte address. Commands arrive one per cycle on a valid/opcode port. They can build a bounds pair from a base and a last-byte address, test an address against one limit, load a register from the command port, read a register out, or clear the fault status.

The lower test and the upper test are separate commands, so a multi-byte access is covered by two of them. For a 4-byte access at address `p`, the lower test uses `p` and the upper test uses `p+3`. Every test gives its result in the next cycle. A violation raises a one-cycle fault strobe and records a 2-bit code in a status register. That register keeps the code until an explicit clear command.

Top module: `bnd_check_unit`

## Requirements
- R1: There are four bounds registers, selected by `cmdIdx`. A register read out on `rdBounds` carries its lower limit in bits 63:0 and its upper limit in bits 127:64.
- R2: After reset every register has lower limit 0 and upper limit all ones. `faultStatus` is 2'b00, and `chkDone`, `chkPass`, `faultPulse` and `rdValid` are 0.
- R3: Opcode 3'd1 (make) writes `cmdAddr` as the lower limit and `cmdLimit` as the upper limit of register `cmdIdx`. A command in the very next cycle sees the new value.
- R4: Opcode 3'd2 (lower test) is a violation exactly when `cmdAddr` is below the selected lower limit, compared as unsigned 64-bit numbers. An address equal to the limit passes.
- R5: Opcode 3'd3 (upper test) is a violation exactly when `cmdAddr` is above the selected upper limit, compared as unsigned 64-bit numbers. An address equal to the limit passes.
- R6: In the cycle after a test command, `chkDone` is 1 and `chkPass` shows the result. `faultPulse` is 1 in that cycle only if the test failed. None of these outputs is raised for any other command.
- R7: A violation writes status code 2'b01. A passing test leaves the status unchanged. Opcode 3'd6 writes 2'b00. No other command changes the status, and code 2'b11 is never written.
- R8: Opcode 3'd4 (load) writes `cmdAddr` as the lower limit and `cmdLimit` as the upper limit. Opcode 3'd5 (read) presents the selected register on `rdBounds` with `rdValid` high one cycle later.
- R9: Opcodes 3'd0 and 3'd7 change no register and no status, and raise no output strobe.
- R10: While `cmdValid` is low, the opcode is ignored. No register, status or strobe changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command opcode |
| cmdIdx | input | 2 | Bounds register select |
| cmdAddr | input | 64 | Tested address, base, or lower limit to load |
| cmdLimit | input | 64 | Last-byte address or upper limit to load |
| chkDone | output | 1 | A test completed last cycle |
| chkPass | output | 1 | Result of that test |
| faultPulse | output | 1 | One-cycle violation strobe |
| faultStatus | output | 2 | Held fault code |
| rdValid | output | 1 | `rdBounds` holds read data |
| rdBounds | output | 128 | Register read out, upper limit in the high half |

## Verification
The tests probe each limit with addresses one below it, equal to it and one above it. This separates strict comparisons from inclusive ones, and it shows whether the two limits are swapped. A region whose lower limit has bit 63 set, tested with 0x7FFF_FFFF_FFFF_FFFF, tells an unsigned comparator from a signed one. A 4-byte access is tested at a start address that fits and at one that overruns by a byte. Mixed sequences of passing tests, failing tests and clears show that the status holds between a fault and the next clear.

// File: rtl/bnd_pkg.sv
package bnd_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_MAKE   = 3'd1,
    OP_CHK_LO = 3'd2,
    OP_CHK_HI = 3'd3,
    OP_LOAD   = 3'd4,
    OP_READ   = 3'd5,
    OP_CLEAR  = 3'd6,
    OP_RSVD   = 3'd7
  } bndOp_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_BOUND  = 2'b01,
    ST_DIR    = 2'b10,
    ST_RSVD   = 2'b11
  } bndStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic chkLo;
    logic chkHi;
    logic rdEn;
  } bndCtl_t;

endpackage

// File: rtl/bnd_datapath.sv
module bnd_datapath
  import bnd_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int WORD_W  = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bndCtl_t           ctl,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] cmdLimit,
  output logic              violation,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdBounds
);

  logic [ADDR_W-1:0] loReg [NUM_REGS];
  logic [ADDR_W-1:0] hiReg [NUM_REGS];
  logic [ADDR_W-1:0] selLo;
  logic [ADDR_W-1:0] selHi;
  logic              belowLo;
  logic              aboveHi;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gBnd
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        loReg[g] <= '0;
        hiReg[g] <= '1;
      end else if (ctl.wrEn && cmdIdx == MY_IDX) begin
        loReg[g] <= cmdAddr;
        hiReg[g] <= cmdLimit;
      end
    end
  end

  always_comb begin
    selLo   = loReg[cmdIdx];
    selHi   = hiReg[cmdIdx];
    belowLo = cmdAddr < selLo;
    aboveHi = cmdAddr > selHi;
    violation = (ctl.chkLo && belowLo) || (ctl.chkHi && aboveHi);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdBounds <= '0;
    end else begin
      rdValid <= ctl.rdEn;
      if (ctl.rdEn) rdBounds <= {selHi, selLo};
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.wrEn) |-> (loReg[$past(cmdIdx)] == $past(cmdAddr) &&
                         hiReg[$past(cmdIdx)] == $past(cmdLimit))); // R3

  AST_READ_STROBE_SOLO: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!ctl.chkLo && !ctl.chkHi && !ctl.wrEn)); // R8

endmodule

// File: rtl/bnd_ctrl.sv
module bnd_ctrl
  import bnd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       violation,
  output bndCtl_t    ctl,
  output logic       chkDone,
  output logic       chkPass,
  output logic       faultPulse,
  output logic [1:0] faultStatus
);

  bndOp_e     opCode;
  logic       isCheck;
  logic       isClear;
  bndStatus_e statusQ;

  always_comb begin
    opCode    = bndOp_e'(cmdOp);
    ctl       = '0;
    isCheck   = 1'b0;
    isClear   = 1'b0;
    if (cmdValid) begin
      unique case (opCode)
        OP_MAKE, OP_LOAD: ctl.wrEn  = 1'b1;
        OP_CHK_LO: begin ctl.chkLo = 1'b1; isCheck = 1'b1; end
        OP_CHK_HI: begin ctl.chkHi = 1'b1; isCheck = 1'b1; end
        OP_READ:          ctl.rdEn  = 1'b1;
        OP_CLEAR:         isClear   = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkDone    <= 1'b0;
      chkPass    <= 1'b0;
      faultPulse <= 1'b0;
      statusQ    <= ST_OK;
    end else begin
      chkDone    <= isCheck;
      chkPass    <= isCheck && !violation;
      faultPulse <= isCheck && violation;
      if (isCheck && violation) statusQ <= ST_BOUND;
      else if (isClear)         statusQ <= ST_OK;
    end
  end

  assign faultStatus = statusQ;

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    faultStatus != 2'b11); // R7

  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> faultStatus == 2'b01); // R7

  AST_FAULT_FROM_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> $past(cmdValid) &&
                   ($past(cmdOp) == 3'd2 || $past(cmdOp) == 3'd3)); // R6

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (chkPass || faultPulse) |-> chkDone && !(chkPass && faultPulse)); // R6

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!faultPulse && !$past(cmdValid && cmdOp == 3'd6)) |-> $stable(faultStatus)); // R7

endmodule

// File: rtl/bnd_check_unit.sv
module bnd_check_unit
  import bnd_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int WORD_W  = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] cmdLimit,
  output logic              chkDone,
  output logic              chkPass,
  output logic              faultPulse,
  output logic [1:0]        faultStatus,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdBounds
);

  bndCtl_t ctl;
  logic    violation;

  bnd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .violation(violation), .ctl(ctl), .chkDone(chkDone), .chkPass(chkPass),
    .faultPulse(faultPulse), .faultStatus(faultStatus)
  );

  bnd_datapath #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdIdx(cmdIdx), .cmdAddr(cmdAddr),
    .cmdLimit(cmdLimit), .violation(violation), .rdValid(rdValid),
    .rdBounds(rdBounds)
  );

endmodule

// File: tb/bnd_check_unit_test.sv
module bnd_check_unit_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic [2:0]   cmdOp = '0;
  logic [1:0]   cmdIdx = '0;
  logic [63:0]  cmdAddr = '0;
  logic [63:0]  cmdLimit = '0;
  logic         chkDone, chkPass, faultPulse, rdValid;
  logic [1:0]   faultStatus;
  logic [127:0] rdBounds;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  bnd_check_unit uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .cmdAddr(cmdAddr), .cmdLimit(cmdLimit), .chkDone(chkDone), .chkPass(chkPass),
    .faultPulse(faultPulse), .faultStatus(faultStatus), .rdValid(rdValid),
    .rdBounds(rdBounds)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  idx;
    logic [63:0] a;
    logic [63:0] b;
    logic        done;
    logic        pass;
    logic [1:0]  st;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 2'd1, 64'h1000, 64'h118F, 1'b0, 1'b0, 2'b00}, // R3 make
    '{3'd2, 2'd1, 64'h1000, 64'h0,    1'b1, 1'b1, 2'b00}, // R4 equal
    '{3'd2, 2'd1, 64'h0FFF, 64'h0,    1'b1, 1'b0, 2'b01}, // R4 below
    '{3'd3, 2'd1, 64'h118F, 64'h0,    1'b1, 1'b1, 2'b01}, // R5 equal, R7 hold
    '{3'd6, 2'd0, 64'h0,    64'h0,    1'b0, 1'b0, 2'b00}, // R7 clear
    '{3'd3, 2'd1, 64'h1190, 64'h0,    1'b1, 1'b0, 2'b01}, // R5 above
    '{3'd6, 2'd0, 64'h0,    64'h0,    1'b0, 1'b0, 2'b00},
    '{3'd2, 2'd1, 64'h118C, 64'h0,    1'b1, 1'b1, 2'b00}, // 4-byte fits
    '{3'd3, 2'd1, 64'h118F, 64'h0,    1'b1, 1'b1, 2'b00},
    '{3'd3, 2'd1, 64'h1190, 64'h0,    1'b1, 1'b0, 2'b01}, // 4-byte at 118D
    '{3'd6, 2'd0, 64'h0,    64'h0,    1'b0, 1'b0, 2'b00},
    '{3'd3, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b1, 2'b00}, // R2 open
    '{3'd2, 2'd0, 64'h0,    64'h0,    1'b1, 1'b1, 2'b00},
    '{3'd1, 2'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 1'b0, 2'b00},
    '{3'd2, 2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0, 2'b01}, // unsigned
    '{3'd3, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0, 2'b01},
    '{3'd3, 2'd2, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 1'b1, 1'b1, 2'b01},
    '{3'd2, 2'd2, 64'h8000_0000_0000_0000, 64'h0, 1'b1, 1'b1, 2'b01}
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic doCmd(input bit v, input logic [2:0] op, input logic [1:0] idx,
                       input logic [63:0] a, input logic [63:0] b);
    cmdValid = v; cmdOp = op; cmdIdx = idx; cmdAddr = a; cmdLimit = b;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2 reset state
    check(faultStatus == 2'b00, "R2 status", faultStatus, 0);
    check({chkDone, chkPass, faultPulse, rdValid} == 4'b0, "R2 strobes",
          {chkDone, chkPass, faultPulse, rdValid}, 0);
    doCmd(1, 3'd5, 2'd3, 0, 0);
    check(rdValid && rdBounds == {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, "R2 R1 read r3",
          rdBounds, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0});

    for (int i = 0; i < NV; i++) begin
      doCmd(1, VEC[i].op, VEC[i].idx, VEC[i].a, VEC[i].b);
      check(chkDone == VEC[i].done, "R6 done", chkDone, VEC[i].done);
      check(chkPass == VEC[i].pass, "R4 R5 pass", chkPass, VEC[i].pass);
      check(faultPulse == (VEC[i].done && !VEC[i].pass), "R6 fault", faultPulse,
            VEC[i].done && !VEC[i].pass);
      check(faultStatus == VEC[i].st, "R7 status", faultStatus, VEC[i].st);
    end

    // R8 load and read, field positions per R1
    doCmd(1, 3'd4, 2'd3, 64'h1111, 64'h2222);
    check(!chkDone && !rdValid, "R8 load strobes", {chkDone, rdValid}, 0);
    doCmd(1, 3'd5, 2'd3, 0, 0);
    check(rdValid && rdBounds == {64'h2222, 64'h1111}, "R8 R1 read", rdBounds,
          {64'h2222, 64'h1111});

    // R10 invalid command ignored
    doCmd(0, 3'd1, 2'd3, 64'h5555, 64'h6666);
    check(!chkDone && !rdValid && faultStatus == 2'b01, "R10 idle", faultStatus, 1);
    doCmd(0, 3'd6, 2'd0, 0, 0);
    check(faultStatus == 2'b01, "R10 clear ignored", faultStatus, 1);
    doCmd(1, 3'd5, 2'd3, 0, 0);
    check(rdBounds == {64'h2222, 64'h1111}, "R10 reg kept", rdBounds, {64'h2222, 64'h1111});

    // R9 reserved and no-op opcodes
    doCmd(1, 3'd7, 2'd3, 64'h7777, 64'h8888);
    check(!chkDone && !faultPulse && !rdValid && faultStatus == 2'b01, "R9 op7",
          faultStatus, 1);
    doCmd(1, 3'd0, 2'd3, 64'h9999, 64'hAAAA);
    check(!chkDone && !rdValid && faultStatus == 2'b01, "R9 nop", faultStatus, 1);
    doCmd(1, 3'd5, 2'd3, 0, 0);
    check(rdBounds == {64'h2222, 64'h1111}, "R9 reg kept", rdBounds, {64'h2222, 64'h1111});

    // R3 back-to-back make then test
    doCmd(1, 3'd6, 2'd0, 0, 0);
    doCmd(1, 3'd1, 2'd0, 64'h40, 64'h4F);
    doCmd(1, 3'd3, 2'd0, 64'h50, 0);
    check(faultPulse && faultStatus == 2'b01, "R3 next-cycle use", faultStatus, 1);
    // R6 strobe lasts one cycle
    doCmd(1, 3'd0, 2'd0, 0, 0);
    check(!faultPulse && !chkDone, "R6 single pulse", faultPulse, 0);
    check(faultStatus == 2'b01, "R7 held", faultStatus, 1);
    doCmd(1, 3'd6, 2'd0, 0, 0);
    check(faultStatus == 2'b00, "R7 clear", faultStatus, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule